// File: doc/BRIEF.md
# Programmable Bus Timeout Unit

This block watches transfers on a backplane bus and ends any transfer that goes unanswered. Timing begins when the data strobe is first sampled asserted. If a data acknowledge or a bus error from another agent arrives first, the transfer is left alone. If the programmed limit runs out first, the block drives a bus-error termination. It holds that termination until the strobe is released.

The limit is picked by a 4-bit select code. A prescaler divides the clock down to a base tick, which is 1 µs with the default parameters. The limit is then `BASE_TICKS << n` ticks, where n is the code clamped to 14. With the defaults this spans 16 µs to about 262 ms.

Transfers flagged as forwarded over the extender cable are never timed here, because the far side times them. An enable input switches the whole unit off. A sticky flag records that a timeout happened, and it stays set until software clears it.

Top module: `cycle_timeout_unit`

## Requirements
- R1: After reset, `berr_drive_o` and `timeout_flag_o` are both 0.
- R2: The timeout latency is exact. Let the strobe be held with no acknowledge, no incoming bus error and no forwarded flag, with enable high. If the strobe is first sampled high at clock edge k, then `berr_drive_o` goes to 1 at edge k + CLK_PER_TICK·BASE_TICKS·2^n. Here n is the value of `limit_sel_i`.
- R3: An acknowledge or an incoming bus error sampled at or before the expiry edge ends the transfer with no drive. The drive then stays 0 until the strobe is released.
- R4: Once driven, `berr_drive_o` stays 1 while the strobe and enable stay high. It falls at the first edge that samples the strobe low. A new strobe afterwards is timed from zero.
- R5: While `remote_i` is sampled high at the start of a transfer, or at any edge during timing, the transfer is exempt and is never timed out.
- R6: With `enable_i` low the unit never drives bus error. Lowering enable during a drive removes the drive at the next edge.
- R7: Select codes 15 and 14 give the same limit.
- R8: `timeout_flag_o` becomes 1 at the same edge as a timeout drive. It stays 1 until an edge samples `flag_clear_i` high. If a timeout and a clear fall on the same edge, the timeout wins.
- R9: A strobe released before expiry produces no drive. Time elapsed in that transfer does not carry over to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Data strobe asserted (active high, synchronous) |
| ack_i | input | 1 | Data acknowledge seen on the bus |
| berr_in_i | input | 1 | Bus error driven by another agent |
| remote_i | input | 1 | Current transfer is forwarded over the extender cable |
| enable_i | input | 1 | Unit enable |
| limit_sel_i | input | 4 | Timeout select code n, limit = BASE_TICKS·2^min(n,14) ticks |
| flag_clear_i | input | 1 | Clears the sticky timeout flag |
| berr_drive_o | output | 1 | Bus-error termination drive |
| timeout_flag_o | output | 1 | Sticky record of a timeout |

## Verification
The assertions take all bus inputs to be synchronous to `clk` already. They also take `limit_sel_i` to be held steady for the whole of a timed transfer. The hold, release, disable, exemption and sticky-flag properties rely only on these assumptions.

The bench drives every input on the falling edge, so each input is a clean synchronous level. It changes the select code only while the strobe is low. A behavioural reference model tracks elapsed cycles as an integer and is compared against the outputs on every clock. Directed transfers cover the expiry edge itself, with an acknowledge landing on that exact edge and with a clear coinciding with expiry.

// File: rtl/cto_pkg.sv
package cto_pkg;
  // Largest exponent honoured by the select code; larger codes clamp here.
  localparam int unsigned MAX_EXP = 14;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TIMING  = 2'd1,
    ST_EXPIRED = 2'd2,
    ST_DONE    = 2'd3
  } cto_state_e;
endpackage

// File: rtl/cto_prescaler.sv
// Produces one tick every CLK_PER_TICK clocks while run_i is high;
// restarts from zero whenever run_i drops.
module cto_prescaler #(
  parameter int unsigned CLK_PER_TICK = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (CLK_PER_TICK <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_divide
      localparam int unsigned PW = $clog2(CLK_PER_TICK);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        pre_d = pre_q;
        if (!run_i)            pre_d = '0;
        else if (pre_q == LAST) pre_d = '0;
        else                   pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick_o = run_i && (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/cto_interval.sv
// Counts prescaled ticks during a timed transfer and flags the tick that
// completes the selected limit.
module cto_interval
  import cto_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [3:0] sel_i,
  output logic       expire_o
);
  localparam int unsigned CW = $clog2(BASE_TICKS) + MAX_EXP + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;
  logic [3:0]    exp_n;

  always_comb begin
    exp_n = (sel_i > 4'(MAX_EXP)) ? 4'(MAX_EXP) : sel_i;
    limit = CW'(BASE_TICKS) << exp_n;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = run_i && tick_i && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/cto_fsm.sv
// Transfer tracking: idle, timing, expired (driving), done (answered or exempt).
module cto_fsm
  import cto_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic ack_i,
  input  logic berr_in_i,
  input  logic remote_i,
  input  logic enable_i,
  input  logic expire_i,
  input  logic flag_clear_i,
  output logic run_o,
  output logic berr_o,
  output logic flag_o
);
  cto_state_e state_q, state_d;
  logic       flag_q, flag_d;
  logic       answered;

  assign answered = ack_i || berr_in_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (strobe_i)
          state_d = (enable_i && !remote_i && !answered) ? ST_TIMING : ST_DONE;
      end
      ST_TIMING: begin
        if (!enable_i || !strobe_i)   state_d = ST_IDLE;
        else if (answered || remote_i) state_d = ST_DONE;
        else if (expire_i)            state_d = ST_EXPIRED;
      end
      ST_EXPIRED: begin
        if (!enable_i || !strobe_i) state_d = ST_IDLE;
      end
      default: begin
        if (!strobe_i) state_d = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_clear_i) flag_d = 1'b0;
    if (state_q == ST_TIMING && state_d == ST_EXPIRED) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  assign run_o  = (state_q == ST_TIMING);
  assign berr_o = (state_q == ST_EXPIRED);
  assign flag_o = flag_q;
endmodule

// File: rtl/cycle_timeout_unit.sv
module cycle_timeout_unit #(
  parameter int unsigned CLK_PER_TICK = 250,
  parameter int unsigned BASE_TICKS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_i,
  input  logic       ack_i,
  input  logic       berr_in_i,
  input  logic       remote_i,
  input  logic       enable_i,
  input  logic [3:0] limit_sel_i,
  input  logic       flag_clear_i,
  output logic       berr_drive_o,
  output logic       timeout_flag_o
);
  logic run, tick, expire;

  cto_prescaler #(.CLK_PER_TICK(CLK_PER_TICK)) i_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_o(tick)
  );

  cto_interval #(.BASE_TICKS(BASE_TICKS)) i_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
    .sel_i(limit_sel_i), .expire_o(expire)
  );

  cto_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .ack_i(ack_i),
    .berr_in_i(berr_in_i), .remote_i(remote_i), .enable_i(enable_i),
    .expire_i(expire), .flag_clear_i(flag_clear_i),
    .run_o(run), .berr_o(berr_drive_o), .flag_o(timeout_flag_o)
  );
endmodule

// File: rtl/cto_checker.sv
module cto_checker (
  input logic clk,
  input logic rst_n,
  input logic strobe_i,
  input logic ack_i,
  input logic berr_in_i,
  input logic remote_i,
  input logic enable_i,
  input logic flag_clear_i,
  input logic berr_drive_o,
  input logic timeout_flag_o
);
  // R4: a drive persists while strobe and enable stay high
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_drive_o && strobe_i && enable_i) |=> berr_drive_o);

  // R4: strobe release removes the drive
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> !berr_drive_o);

  // R6: disabled unit never drives
  a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !berr_drive_o);

  // R5: forwarded transfers are never timed out
  a_r5_remote_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_drive_o && remote_i) |=> !berr_drive_o);

  // R3: an answered transfer is not terminated
  a_r3_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_drive_o && (ack_i || berr_in_i)) |=> !berr_drive_o);

  // R8: flag set together with the drive
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_drive_o) |-> timeout_flag_o);

  // R8: flag sticky until cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag_o && !flag_clear_i) |=> timeout_flag_o);
endmodule

bind cycle_timeout_unit cto_checker i_chk (
  .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .ack_i(ack_i),
  .berr_in_i(berr_in_i), .remote_i(remote_i), .enable_i(enable_i),
  .flag_clear_i(flag_clear_i), .berr_drive_o(berr_drive_o),
  .timeout_flag_o(timeout_flag_o)
);

// File: tb/test_cycle_timeout_unit.sv
`timescale 1ns/1ps
module test_cycle_timeout_unit;
  localparam int P    = 2;
  localparam int BASE = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic strobe, ack, berr_in, remote, enable, clr;
  logic [3:0] sel;
  logic berr_drive, flag;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  cycle_timeout_unit #(.CLK_PER_TICK(P), .BASE_TICKS(BASE)) i_cycle_timeout_unit (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .ack_i(ack),
    .berr_in_i(berr_in), .remote_i(remote), .enable_i(enable),
    .limit_sel_i(sel), .flag_clear_i(clr),
    .berr_drive_o(berr_drive), .timeout_flag_o(flag)
  );

  function automatic int cyc(input int code);
    int n;
    n = (code > 14) ? 14 : code;
    return P * BASE * (1 << n);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- reference model: elapsed-cycle bookkeeping -------------
  int m_mode;     // 0 idle, 1 timing, 2 expired, 3 answered/exempt
  int m_elapsed;
  bit m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_elapsed = 0; m_flag = 0;
    end else begin
      int  nm;
      bit  set;
      nm  = m_mode;
      set = 0;
      case (m_mode)
        0: if (strobe) begin
             if (enable && !remote && !ack && !berr_in) begin nm = 1; m_elapsed = 0; end
             else nm = 3;
           end
        1: if (!enable || !strobe) nm = 0;
           else begin
             m_elapsed++;
             if (ack || berr_in || remote) nm = 3;
             else if (m_elapsed == cyc(sel)) begin nm = 2; set = 1; end
           end
        2: if (!enable || !strobe) nm = 0;
        default: if (!strobe) nm = 0;
      endcase
      if (clr) m_flag = 0;
      if (set) m_flag = 1;
      m_mode = nm;
    end
  end

  // R2 / R8 every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(berr_drive == (m_mode == 2), "R2 model berr_drive", berr_drive, m_mode == 2);
      check(flag == m_flag, "R8 model flag", flag, m_flag);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle_bus();
    @(negedge clk);
    strobe = 0; ack = 0; berr_in = 0; remote = 0; clr = 0;
    @(negedge clk);
  endtask

  // Raise strobe and count falling edges until the drive appears.
  task automatic measure(input int code, input string req);
    int n;
    @(negedge clk);
    sel = code[3:0];
    strobe = 1;
    n = 0;
    for (int i = 0; i < cyc(code) + 20; i++) begin
      @(negedge clk);
      n++;
      if (berr_drive) break;
    end
    check(n == cyc(code) + 1, req, n, cyc(code) + 1);
  endtask

  task automatic quiet_for(input int cycles, input string req);
    bit seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (berr_drive) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  initial begin
    rst_n = 0; strobe = 0; ack = 0; berr_in = 0; remote = 0;
    enable = 1; clr = 0; sel = 0;
    repeat (3) @(negedge clk);
    check(berr_drive == 0, "R1 reset berr_drive", berr_drive, 0);
    check(flag == 0, "R1 reset flag", flag, 0);
    rst_n = 1;
    idle_bus();

    // R2: latency for two codes
    measure(0, "R2 latency code 0");
    check(flag == 1, "R8 flag set on timeout", flag, 1);
    repeat (5) @(negedge clk);
    check(berr_drive == 1, "R4 drive held while strobe high", berr_drive, 1);
    strobe = 0;
    @(negedge clk);
    check(berr_drive == 0, "R4 drive released with strobe", berr_drive, 0);
    // R4: restart from zero right away
    measure(3, "R4 restart latency code 3");
    check(flag == 1, "R8 flag still set", flag, 1);
    clr = 1;
    @(negedge clk);
    clr = 0;
    check(flag == 0, "R8 flag cleared", flag, 0);
    idle_bus();

    // R8: clear held across expiry -> set wins at that edge
    clr = 1;
    measure(1, "R2 latency code 1");
    check(flag == 1, "R8 set wins over clear", flag, 1);
    @(negedge clk);
    check(flag == 0, "R8 clear after coincident edge", flag, 0);
    clr = 0;
    idle_bus();

    // R3: acknowledge sampled exactly at the expiry edge
    sel = 2;
    @(negedge clk);
    strobe = 1;
    repeat (cyc(2)) @(negedge clk);
    ack = 1;
    @(negedge clk);
    ack = 0;
    quiet_for(3 * cyc(2), "R3 ack at expiry edge");
    idle_bus();

    // R3: incoming bus error early
    @(negedge clk);
    strobe = 1;
    repeat (3) @(negedge clk);
    berr_in = 1;
    @(negedge clk);
    berr_in = 0;
    quiet_for(3 * cyc(2), "R3 incoming bus error");
    idle_bus();

    // R9: early release, then a fresh full-length count
    sel = 2;
    @(negedge clk);
    strobe = 1;
    repeat (cyc(2) - 2) @(negedge clk);
    strobe = 0;
    quiet_for(2, "R9 early release no drive");
    measure(2, "R9 no carry-over latency");
    idle_bus();

    // R5: forwarded at start
    remote = 1;
    @(negedge clk);
    strobe = 1;
    quiet_for(3 * cyc(2), "R5 forwarded at start");
    idle_bus();
    // R5: forwarded flag rises mid-transfer
    @(negedge clk);
    strobe = 1;
    repeat (4) @(negedge clk);
    remote = 1;
    @(negedge clk);
    remote = 0;
    quiet_for(3 * cyc(2), "R5 forwarded mid-transfer");
    idle_bus();

    // R6: disabled for a whole transfer
    enable = 0;
    @(negedge clk);
    strobe = 1;
    quiet_for(3 * cyc(2), "R6 disabled transfer");
    idle_bus();
    enable = 1;
    // R6: disable during a drive
    measure(0, "R2 latency before disable");
    enable = 0;
    @(negedge clk);
    check(berr_drive == 0, "R6 drive dropped on disable", berr_drive, 0);
    enable = 1;
    idle_bus();

    // R7: code 14 and code 15 give the same limit
    measure(14, "R7 latency code 14");
    idle_bus();
    measure(15, "R7 latency code 15 clamps to 14");
    idle_bus();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule